// File: doc/BRIEF.md
# Power-Line Carrier Command Transmitter

This block sends one home-control command over a power-line carrier modem. The command has a 4-bit house address, a 5-bit key or function code and a repeat count, and it arrives through a valid/ready handshake. The mains zero-crossing signal is synchronised inside the block. Each of its edges, rising or falling, marks the boundary of one half-cycle bit slot. In a slot that carries a 1, the carrier-enable output gives a short pulse just after the boundary. In a slot that carries a 0, the output stays low.

A frame takes 22 slots. It opens with four slots holding 1,1,1,0. Nine data bits follow, four for the house and then five for the key, most significant bit first. Each data bit takes two slots, the true value and then its complement. Before the first copy of the frame the block waits for a clean zero crossing and then lets six silent half-cycles pass. The frame is then sent as many times as requested, with no gap between copies. The spacing of the zero crossings is checked at every boundary. A spacing that is too short or too long stops the transmission with the carrier off. The block ends every command with a one-cycle done pulse and a status code.

All timing counts a 1 µs tick taken from the clock by a divider. The half-cycle length, the pulse width and the sync limits are parameters, and the framing window scales with the half-cycle length.

Top module: `plc_frame_tx`

## Requirements
- R1: After reset, cmd_ready is 1 and carrier and done are 0.
- R2: A command with cmd_house ≥ 16 or cmd_key ≥ 32 sends nothing. On the clock after acceptance, done pulses with status 01.
- R3: A frame is slot values 1,1,1,0, then for each of 9 data bits (house nibble, then key bits, first-sent bit first) the bit and then its complement. House codes 0..15 map to nibbles 0110,1110,0010,1010,0001,1001,0101,1101,0111,1111,0011,1011,0000,1000,0100,1100.
- R4: Key codes 0..15 send the house nibble of the same index followed by 0. A function code f in 16..31 sends the 5-bit value 2·(f−16)+1, so 16 sends 00001 and 31 sends 11111.
- R5: In a 1-slot, carrier rises within a few clocks (well under 25 µs) of a zero-crossing transition and stays high for PULSE_US µs (±1 µs). In a 0-slot it stays low. Carrier is never high outside a frame.
- R6: Rising and falling zero-crossing edges both act as slot boundaries.
- R7: The first frame slot begins at the sixth zero-crossing edge after the sync edge, so six silent half-cycles come before the frame.
- R8: The frame is sent cmd_reps times with no gap between copies, and done then pulses with status 00. With cmd_reps = 0, done with status 00 comes at that sixth edge and nothing is sent.
- R9: If a slot edge comes fewer than PULSE_US + 0.72·HALF_US µs after the previous boundary, transmission stops. The carrier is low from the next clock, and done pulses with status 11.
- R10: If no edge comes within the upper window limit (1.02·HALF_US µs in the gap, plus PULSE_US during the frame), done pulses with status 11.
- R11: A sync attempt fails if its edge comes within CLEAN_US µs of the start of the wait, or if no edge comes within SYNC_TIMEOUT_US µs. After SYNC_TRIES failed attempts, done pulses with status 10.
- R12: cmd_ready is 0 from the clock after a valid command is accepted until done, and done is high for exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| zc_in | input | 1 | Asynchronous mains zero-crossing level |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command accepted when valid |
| cmd_house | input | CMD_W | House address, 0..15 legal |
| cmd_key | input | CMD_W | Key/function code, 0..31 legal |
| cmd_reps | input | REP_W | Number of back-to-back frame copies |
| carrier | output | 1 | Carrier enable to the modem |
| done | output | 1 | One-clock end-of-command pulse |
| status | output | 2 | 00 sent, 01 rejected, 10 sync error, 11 framing error |

## Verification
The bench builds the block with CLK_PER_US = 2, which exercises the divider branch rather than the every-clock tick. It uses HALF_US = 50 and PULSE_US = 5, so a whole multi-copy frame takes a few thousand clocks. With CLEAN_US = 2 and SYNC_TIMEOUT_US = 200, a run of ten timed-out sync attempts stays short enough to measure its length exactly. A stopped, fast or hand-toggled zero-crossing input then drives the late-edge, unclean-edge and early-edge abort paths.

// File: rtl/plc_tx_pkg.sv
package plc_tx_pkg;

   localparam int FRAME_SLOTS = 22;

   typedef enum logic [1:0] {
      ST_OK     = 2'b00,
      ST_BADCMD = 2'b01,
      ST_SYNC   = 2'b10,
      ST_FRAME  = 2'b11
   } plc_status_e;

   // house address to its 4-bit line nibble, first-sent bit in bit 3
   function automatic logic [3:0] house_nib(input logic [3:0] h);
      logic [3:0] n;
      case (h)
         4'd0:  n = 4'b0110;
         4'd1:  n = 4'b1110;
         4'd2:  n = 4'b0010;
         4'd3:  n = 4'b1010;
         4'd4:  n = 4'b0001;
         4'd5:  n = 4'b1001;
         4'd6:  n = 4'b0101;
         4'd7:  n = 4'b1101;
         4'd8:  n = 4'b0111;
         4'd9:  n = 4'b1111;
         4'd10: n = 4'b0011;
         4'd11: n = 4'b1011;
         4'd12: n = 4'b0000;
         4'd13: n = 4'b1000;
         4'd14: n = 4'b0100;
         default: n = 4'b1100;
      endcase
      return n;
   endfunction

   // unit keys reuse the nibble plus a 0; functions are odd values
   function automatic logic [4:0] key_bits(input logic [4:0] k);
      return k[4] ? {k[3:0], 1'b1} : {house_nib(k[3:0]), 1'b0};
   endfunction

   // slot 0 in bit 21
   function automatic logic [FRAME_SLOTS-1:0] frame_bits(input logic [3:0] h,
                                                         input logic [4:0] k);
      logic [8:0]             d;
      logic [FRAME_SLOTS-1:0] f;
      d = {house_nib(h), key_bits(k)};
      f = '0;
      f[21:18] = 4'b1110;
      for (int i = 0; i < 9; i++) begin
         f[17-2*i] = d[8-i];
         f[16-2*i] = ~d[8-i];
      end
      return f;
   endfunction

endpackage

// File: rtl/plc_us_tick.sv
module plc_us_tick #(
   parameter int CLK_PER_US = 50
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   generate
      if (CLK_PER_US < 1) begin : g_bad
         $error("CLK_PER_US must be at least 1");
      end
      if (CLK_PER_US == 1) begin : g_direct
         assign tick = 1'b1;
      end else begin : g_div
         localparam int DW = $clog2(CLK_PER_US);
         localparam logic [DW-1:0] LAST = DW'(CLK_PER_US - 1);
         logic [DW-1:0] div_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             div_q <= '0;
            else if (div_q == LAST) div_q <= '0;
            else                    div_q <= div_q + 1'b1;
         end
         assign tick = (div_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/plc_zc_edge.sv
module plc_zc_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic zc_in,
   output logic zc_edge
);
   logic s1_q, s2_q, prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_q   <= 1'b0;
         s2_q   <= 1'b0;
         prev_q <= 1'b0;
      end else begin
         s1_q   <= zc_in;
         s2_q   <= s1_q;
         prev_q <= s2_q;
      end
   end

   // either polarity marks a slot boundary
   assign zc_edge = s2_q ^ prev_q;
endmodule

// File: rtl/plc_us_timer.sv
module plc_us_timer #(
   parameter int LIMIT = 1000,
   localparam int TW = $clog2(LIMIT + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          tick,
   output logic [TW-1:0] cnt
);
   localparam logic [TW-1:0] TOP = TW'(LIMIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt <= '0;
      else if (clr)                 cnt <= '0;
      else if (tick && cnt != TOP)  cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/plc_frame_tx.sv
module plc_frame_tx
   import plc_tx_pkg::*;
#(
   parameter int CLK_PER_US      = 50,
   parameter int HALF_US         = 8333,
   parameter int PULSE_US        = 1000,
   parameter int GAP_SLOTS       = 6,
   parameter int SYNC_TRIES      = 10,
   parameter int CLEAN_US        = 100,
   parameter int SYNC_TIMEOUT_US = 250000,
   parameter int CMD_W           = 8,
   parameter int REP_W           = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             zc_in,
   input  logic             cmd_valid,
   output logic             cmd_ready,
   input  logic [CMD_W-1:0] cmd_house,
   input  logic [CMD_W-1:0] cmd_key,
   input  logic [REP_W-1:0] cmd_reps,
   output logic             carrier,
   output logic             done,
   output logic [1:0]       status
);
   localparam int GAP_LO  = HALF_US * 72 / 100;
   localparam int GAP_HI  = HALF_US * 102 / 100;
   localparam int SLOT_LO = GAP_LO + PULSE_US;
   localparam int SLOT_HI = GAP_HI + PULSE_US;
   localparam int LIMIT   = ((SYNC_TIMEOUT_US > SLOT_HI) ? SYNC_TIMEOUT_US : SLOT_HI) + 1;
   localparam int TW      = $clog2(LIMIT + 1);
   localparam int GW      = $clog2(GAP_SLOTS + 1);
   localparam int YW      = $clog2(SYNC_TRIES + 1);
   localparam int SW      = $clog2(FRAME_SLOTS);

   localparam logic [TW-1:0] C_CLEAN = TW'(CLEAN_US);
   localparam logic [TW-1:0] C_TO    = TW'(SYNC_TIMEOUT_US);
   localparam logic [TW-1:0] C_GLO   = TW'(GAP_LO);
   localparam logic [TW-1:0] C_GHI   = TW'(GAP_HI);
   localparam logic [TW-1:0] C_SLO   = TW'(SLOT_LO);
   localparam logic [TW-1:0] C_SHI   = TW'(SLOT_HI);
   localparam logic [TW-1:0] C_PULSE = TW'(PULSE_US);

   generate
      if (CMD_W < 5) begin : g_bad_cmd
         $error("CMD_W must hold a 5-bit key");
      end
      if (PULSE_US < 1 || PULSE_US >= GAP_LO) begin : g_bad_pulse
         $error("PULSE_US must be shorter than the framing window floor");
      end
      if (GAP_SLOTS < 1 || SYNC_TRIES < 1 || REP_W < 1) begin : g_bad_cnt
         $error("gap, try and repeat widths must be positive");
      end
      if (CLEAN_US >= SYNC_TIMEOUT_US) begin : g_bad_sync
         $error("CLEAN_US must be below SYNC_TIMEOUT_US");
      end
   endgenerate

   typedef enum logic [1:0] {S_IDLE, S_SYNC, S_GAP, S_SEND} tx_state_e;

   tx_state_e              state;
   plc_status_e            status_q;
   logic                   done_q, carrier_q;
   logic [YW-1:0]          tries;
   logic [GW-1:0]          gap_cnt;
   logic [SW-1:0]          slot;
   logic [REP_W-1:0]       reps_left;
   logic [FRAME_SLOTS-1:0] frame_q, frame_sr;
   logic                   tick, zc_edge, tmr_clr, accept, cmd_ok, sync_miss;
   logic [TW-1:0]          us_cnt;

   plc_us_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick(tick));

   plc_zc_edge u_edge (
      .clk(clk), .rst_n(rst_n), .zc_in(zc_in), .zc_edge(zc_edge));

   plc_us_timer #(.LIMIT(LIMIT)) u_tmr (
      .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .tick(tick), .cnt(us_cnt));

   assign cmd_ready = (state == S_IDLE);
   assign accept    = cmd_valid && cmd_ready;
   assign cmd_ok    = (cmd_house[CMD_W-1:4] == '0) && (cmd_key[CMD_W-1:5] == '0);
   assign sync_miss = zc_edge ? (us_cnt <= C_CLEAN) : (us_cnt >= C_TO);
   assign tmr_clr   = zc_edge || accept || (state == S_SYNC && sync_miss);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= S_IDLE;
         status_q  <= ST_OK;
         done_q    <= 1'b0;
         carrier_q <= 1'b0;
         tries     <= '0;
         gap_cnt   <= '0;
         slot      <= '0;
         reps_left <= '0;
         frame_q   <= '0;
         frame_sr  <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (state)
            S_IDLE: if (cmd_valid) begin
               if (cmd_ok) begin
                  state     <= S_SYNC;
                  tries     <= '0;
                  reps_left <= cmd_reps;
                  frame_q   <= frame_bits(cmd_house[3:0], cmd_key[4:0]);
               end else begin
                  done_q   <= 1'b1;
                  status_q <= ST_BADCMD;
               end
            end
            S_SYNC: if (zc_edge && !sync_miss) begin
               state   <= S_GAP;
               gap_cnt <= '0;
            end else if (sync_miss) begin
               if (tries == YW'(SYNC_TRIES - 1)) begin
                  state    <= S_IDLE;
                  done_q   <= 1'b1;
                  status_q <= ST_SYNC;
               end else begin
                  tries <= tries + 1'b1;
               end
            end
            S_GAP: if ((zc_edge && (us_cnt < C_GLO || us_cnt > C_GHI)) ||
                       (!zc_edge && us_cnt > C_GHI)) begin
               state    <= S_IDLE;
               done_q   <= 1'b1;
               status_q <= ST_FRAME;
            end else if (zc_edge) begin
               if (gap_cnt != GW'(GAP_SLOTS - 1)) begin
                  gap_cnt <= gap_cnt + 1'b1;
               end else if (reps_left == '0) begin
                  state    <= S_IDLE;
                  done_q   <= 1'b1;
                  status_q <= ST_OK;
               end else begin
                  state     <= S_SEND;
                  slot      <= '0;
                  carrier_q <= frame_q[FRAME_SLOTS-1];
                  frame_sr  <= {frame_q[FRAME_SLOTS-2:0], 1'b0};
               end
            end
            S_SEND: if ((zc_edge && (us_cnt < C_SLO || us_cnt > C_SHI)) ||
                        (!zc_edge && us_cnt > C_SHI)) begin
               state     <= S_IDLE;
               done_q    <= 1'b1;
               status_q  <= ST_FRAME;
               carrier_q <= 1'b0;
            end else if (zc_edge) begin
               if (slot != SW'(FRAME_SLOTS - 1)) begin
                  slot      <= slot + 1'b1;
                  carrier_q <= frame_sr[FRAME_SLOTS-1];
                  frame_sr  <= {frame_sr[FRAME_SLOTS-2:0], 1'b0};
               end else if (reps_left == REP_W'(1)) begin
                  state     <= S_IDLE;
                  done_q    <= 1'b1;
                  status_q  <= ST_OK;
                  carrier_q <= 1'b0;
               end else begin
                  reps_left <= reps_left - 1'b1;
                  slot      <= '0;
                  carrier_q <= frame_q[FRAME_SLOTS-1];
                  frame_sr  <= {frame_q[FRAME_SLOTS-2:0], 1'b0};
               end
            end else if (us_cnt >= C_PULSE) begin
               carrier_q <= 1'b0;
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   assign carrier = carrier_q;
   assign done    = done_q;
   assign status  = status_q;

   // R12
   busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && cmd_ok) |=> !cmd_ready);
   // R12
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);
   // R2
   reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !cmd_ok) |=> (done_q && status_q == ST_BADCMD && !carrier_q));
   // R5
   carrier_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      carrier_q |-> (state == S_SEND));
   // R5
   pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      carrier_q |-> (us_cnt <= C_PULSE));
   // R9
   early_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_SEND && zc_edge && us_cnt < C_SLO) |=>
         (!carrier_q && done_q && status_q == ST_FRAME));
   // R11
   sync_err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_SYNC && sync_miss && tries == YW'(SYNC_TRIES - 1)) |=>
         (done_q && status_q == ST_SYNC));
endmodule

// File: tb/sim_plc_frame_tx.sv
module sim_plc_frame_tx;
   localparam int CLK_PERIOD = 10;
   localparam int CPU        = 2;
   localparam int HALF       = 50;
   localparam int PULSE      = 5;
   localparam int US_NS      = CLK_PERIOD * CPU;

   logic       clk = 1'b0, rst_n = 1'b0, zc = 1'b0;
   logic       cmd_valid = 1'b0;
   logic [7:0] cmd_house = '0, cmd_key = '0, cmd_reps = '0;
   logic       cmd_ready, carrier, done;
   logic [1:0] status;

   int  n_chk = 0, n_fail = 0;
   bit  mon_on = 1'b0, zc_run = 1'b1;
   int  zc_half_ns = HALF * US_NS;
   int  hi_run = 0, rise_pulses = 0, fall_pulses = 0;
   bit  expq[$];

   plc_frame_tx #(.CLK_PER_US(CPU), .HALF_US(HALF), .PULSE_US(PULSE),
                  .GAP_SLOTS(6), .SYNC_TRIES(10), .CLEAN_US(2),
                  .SYNC_TIMEOUT_US(200), .CMD_W(8), .REP_W(8)) u0 (
      .clk(clk), .rst_n(rst_n), .zc_in(zc), .cmd_valid(cmd_valid),
      .cmd_ready(cmd_ready), .cmd_house(cmd_house), .cmd_key(cmd_key),
      .cmd_reps(cmd_reps), .carrier(carrier), .done(done), .status(status));

   always #(CLK_PERIOD/2) clk = ~clk;

   initial forever begin
      if (zc_run) begin
         #(zc_half_ns);
         if (zc_run) zc = ~zc;
      end else #(CLK_PERIOD);
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // scoreboard monitor: one expected slot value per zero-crossing edge
   always begin
      @(zc);
      if (mon_on) begin
         bit e, lvl;
         lvl = zc;
         #(3*US_NS);
         e = (expq.size() > 0) ? expq.pop_front() : 1'b0;
         chk(carrier == e, "R3/R4/R7 slot value", carrier, e);
         if (carrier) begin
            if (lvl) rise_pulses++; else fall_pulses++;
         end
      end
   end

   // R5 pulse width monitor
   always @(posedge clk) begin
      if (carrier) hi_run++;
      else if (hi_run > 0) begin
         if (mon_on)
            chk(hi_run >= (PULSE-1)*CPU && hi_run <= (PULSE+1)*CPU,
                "R5 pulse width", hi_run, PULSE*CPU);
         hi_run = 0;
      end
   end

   function automatic logic [3:0] ref_nib(input int h);
      logic [3:0] t [16] = '{4'b0110, 4'b1110, 4'b0010, 4'b1010, 4'b0001, 4'b1001,
                             4'b0101, 4'b1101, 4'b0111, 4'b1111, 4'b0011, 4'b1011,
                             4'b0000, 4'b1000, 4'b0100, 4'b1100};
      return t[h];
   endfunction

   task automatic push_expect(input int h, input int k, input int reps);
      logic [8:0] d;
      logic [4:0] kb;
      kb = (k < 16) ? {ref_nib(k), 1'b0} : 5'(2*(k-16)+1);
      d  = {ref_nib(h), kb};
      for (int i = 0; i < 6; i++) expq.push_back(1'b0);
      for (int r = 0; r < reps; r++) begin
         expq.push_back(1'b1); expq.push_back(1'b1);
         expq.push_back(1'b1); expq.push_back(1'b0);
         for (int i = 8; i >= 0; i--) begin
            expq.push_back(d[i]);
            expq.push_back(~d[i]);
         end
      end
   endtask

   task automatic issue(input int h, input int k, input int reps);
      @(negedge clk);
      cmd_house = 8'(h); cmd_key = 8'(k); cmd_reps = 8'(reps);
      cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic wait_done(input int max_cyc, input string tag, output int cyc);
      cyc = 0;
      while (!done && cyc < max_cyc) begin
         @(negedge clk);
         cyc++;
      end
      chk(done == 1'b1, tag, done, 1);
   endtask

   task automatic run_frame(input int h, input int k, input int reps, input string tag);
      int cyc;
      push_expect(h, k, reps);
      repeat (2) @(zc);
      #(10*US_NS);
      mon_on = 1'b1;
      issue(h, k, reps);
      chk(cmd_ready == 1'b0, "R12 busy after accept", cmd_ready, 0);
      wait_done(200000, {tag, " done"}, cyc);
      chk(status == 2'b00, {tag, " status"}, status, 0);
      @(negedge clk);
      chk(done == 1'b0, "R12 done one clock", done, 0);
      #(10*US_NS);
      mon_on = 1'b0;
      chk(expq.size() == 0, {tag, " all slots seen"}, expq.size(), 0);
      expq.delete();
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      int cyc;
      bit seen;
      #(CLK_PERIOD * 3);
      @(negedge clk);
      // R1
      chk(cmd_ready == 1'b1, "R1 ready at reset", cmd_ready, 1);
      chk(carrier == 1'b0, "R1 carrier at reset", carrier, 0);
      chk(done == 1'b0, "R1 done at reset", done, 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R2: bad house, then bad key
      issue(16, 3, 2);
      chk(done == 1'b1 && status == 2'b01, "R2 house 16 rejected", status, 1);
      seen = 1'b0;
      repeat (300) begin @(negedge clk); if (carrier) seen = 1'b1; end
      chk(!seen, "R2 no carrier after reject", seen, 0);
      issue(2, 32, 1);
      chk(done == 1'b1 && status == 2'b01, "R2 key 32 rejected", status, 1);
      chk(cmd_ready == 1'b1, "R2 still ready", cmd_ready, 1);

      // R3 R4 R7 R8
      run_frame(0, 0, 1, "R3 house0 key0");
      run_frame(9, 16, 2, "R8 two copies, R4 function 16");
      chk(rise_pulses > 0 && fall_pulses > 0, "R6 pulses on both edge kinds",
          (rise_pulses > 0) + (fall_pulses > 0), 2);
      run_frame(12, 31, 1, "R4 function 31");
      run_frame(5, 13, 1, "R4 unit 14");
      run_frame(7, 4, 0, "R8 zero repeats");

      // R9: early edge while carrier is on
      repeat (2) @(zc);
      #(10*US_NS);
      issue(0, 0, 1);
      @(posedge carrier);
      zc_run = 1'b0;
      #(2*US_NS);
      zc = ~zc;
      wait_done(100, "R9 early edge done", cyc);
      chk(status == 2'b11, "R9 early edge status", status, 3);
      chk(carrier == 1'b0, "R9 carrier forced off", carrier, 0);
      zc_run = 1'b1;

      // R10: edges stop during the gap
      repeat (2) @(zc);
      #(10*US_NS);
      issue(1, 1, 1);
      repeat (2) @(zc);
      zc_run = 1'b0;
      wait_done(400, "R10 late edge done", cyc);
      chk(status == 2'b11, "R10 late edge status", status, 3);
      #(3*HALF*US_NS);

      // R11: no edges at all, ten timeouts of 200 us
      issue(3, 3, 1);
      wait_done(6000, "R11 timeout done", cyc);
      chk(status == 2'b10, "R11 timeout status", status, 2);
      chk(cyc >= 3950 && cyc <= 4100, "R11 ten tries length", cyc, 4000);

      // R11: edges arrive too soon after each wait start
      zc_half_ns = US_NS;
      zc_run = 1'b1;
      #(10*US_NS);
      issue(3, 3, 1);
      wait_done(400, "R11 unclean done", cyc);
      chk(status == 2'b10, "R11 unclean status", status, 2);
      zc_half_ns = HALF * US_NS;
      #(4*HALF*US_NS);

      // recovery after errors
      run_frame(15, 20, 1, "R8 frame after errors");

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule